// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status Controller

This block holds the interrupt status word and the interrupt enable word of a descriptor-based Ethernet DMA engine. The transmit and receive engines around it raise single-cycle event pulses. Each pulse sets a sticky bit in the status word. Software reads the word over a simple register port and clears bits by writing ones to them.

Events are sorted into two groups, a normal group and an abnormal group. Each group has a summary bit that is built only from the events whose own enable bit is set. A single level interrupt output is raised when an enabled summary is active. The status word also carries two read-only fields that show the current process state of the transmit engine and of the receive engine. These states are supplied as inputs and captured once per cycle.

The register port has two addresses: address 0 selects the status word and address 1 selects the enable word. Reads are combinational from the selected register. Writes take effect on the next rising clock edge.

Top module: `eth_dma_irq_ctrl`

## Requirements
- R1: After reset, the status word reads 0, the enable word reads 0, the interrupt output is low, and both process-state fields read 000 (stopped).
- R2: A pulse on event input bit i, for i in 0..10, 13 or 14, sets status bit i at the next rising edge. The bit then stays set until software clears it.
- R3: Writing the status address clears every event bit whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R4: When an event pulse and a write-one clear hit the same status bit on the same edge, the bit ends up set.
- R5: Status bits 11, 12 and 23..31 always read 0. Pulses on event inputs 11 and 12 have no effect.
- R6: Writes to status bits 17..31 leave the process-state fields unchanged, and those bits cannot be written.
- R7: Status bits 22:20 show the transmit state input and bits 19:17 show the receive state input, each one rising edge after the input is applied. Transmit codes: 000 stopped, 001 fetching, 010 waiting, 011 reading, 110 suspended, 111 closing. Receive codes: 000 stopped, 001 fetching, 011 waiting, 100 suspended, 101 closing, 111 transferring.
- R8: Status bit 16 (normal summary) is 1 exactly when one of status bits 0, 2, 6 or 14 is set together with the enable bit at the same position.
- R9: Status bit 15 (abnormal summary) is 1 exactly when one of status bits 1, 3, 4, 5, 7, 8, 9, 10 or 13 is set together with the enable bit at the same position.
- R10: The interrupt output is high exactly when (status bit 16 and enable bit 16) or (status bit 15 and enable bit 15) hold.
- R11: The enable word stores only bits 0..10 and 13..16 (mask 0x1E7FF). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Register select for both read and write: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_i | input | 15 | Event pulses from the DMA engines, one per status bit position |
| tx_state_i | input | 3 | Current transmit process state code |
| rx_state_i | input | 3 | Current receive process state code |
| irq_o | output | 1 | Level interrupt request |

## Verification
Event pulses and register writes land on the rising edge that follows them. Read data, the summary bits and the interrupt output follow combinationally from the registers, so every effect can be seen from the falling edge after that rising edge. The state fields likewise need one rising edge after an input change. The bench applies every stimulus at a falling edge and waits through exactly one rising edge. It then samples at the next falling edge, changing the read address and waiting 1 ns before each read. It sweeps every event position against four enable patterns and every pair of transmit and receive codes, and it compares each read with a model built from the requirements.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int DW      = 32;
  localparam int EVW     = 15;
  localparam int SW      = 3;
  localparam int AIS_POS = 15;
  localparam int NIS_POS = 16;
  localparam int RX_LO   = 17;
  localparam int TX_LO   = 20;

  localparam logic [EVW-1:0] EV_MASK  = 15'h67FF;
  localparam logic [EVW-1:0] NRM_GRP  = 15'h4045;
  localparam logic [EVW-1:0] ABN_GRP  = 15'h27BA;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;

  typedef enum logic [SW-1:0] {
    TXS_STOP  = 3'b000,
    TXS_FETCH = 3'b001,
    TXS_WAIT  = 3'b010,
    TXS_READ  = 3'b011,
    TXS_SUSP  = 3'b110,
    TXS_CLOSE = 3'b111
  } tx_state_e;

  typedef enum logic [SW-1:0] {
    RXS_STOP  = 3'b000,
    RXS_FETCH = 3'b001,
    RXS_WAIT  = 3'b011,
    RXS_SUSP  = 3'b100,
    RXS_CLOSE = 3'b101,
    RXS_XFER  = 3'b111
  } rx_state_e;
endpackage

// File: rtl/eth_irq_sticky.sv
module eth_irq_sticky #(
  parameter int             W    = 15,
  parameter logic [W-1:0]   MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_ff
      logic q_r, q_nxt, q_ld, clr_hit;
      always_comb begin
        clr_hit = clr_we & clr_i[i];
        q_ld    = set_i[i] | clr_hit;
        q_nxt   = set_i[i] | (q_r & ~clr_hit);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_r <= 1'b0;
        else if (q_ld) q_r <= q_nxt;
      end
      assign q_o[i] = q_r;
    end else begin : g_tie
      logic unused_b;
      assign unused_b = set_i[i] ^ clr_i[i];
      assign q_o[i]   = 1'b0;
    end
  end
endmodule

// File: rtl/eth_irq_summary.sv
module eth_irq_summary #(
  parameter int           W   = 15,
  parameter logic [W-1:0] GRP = '1
) (
  input  logic [W-1:0] stk_i,
  input  logic [W-1:0] en_i,
  output logic         sum_o
);
  always_comb sum_o = |(stk_i & en_i & GRP);
endmodule

// File: rtl/eth_irq_state_cap.sv
module eth_irq_state_cap #(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] tx_i,
  input  logic [SW-1:0] rx_i,
  output logic [SW-1:0] tx_q,
  output logic [SW-1:0] rx_q
);
  logic tx_ld, rx_ld;
  always_comb begin
    tx_ld = (tx_i != tx_q);
    rx_ld = (rx_i != rx_q);
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_ld) tx_q <= tx_i;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_q <= '0;
    else if (rx_ld) rx_q <= rx_i;
  end
endmodule

// File: rtl/eth_dma_irq_ctrl.sv
module eth_dma_irq_ctrl
  import eth_irq_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int EVT_W  = EVW,
  parameter int ST_W   = SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [ST_W-1:0]   tx_state_i,
  input  logic [ST_W-1:0]   rx_state_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] EN_MASK =
    DATA_W'(EV_MASK) | (DATA_W'(1) << AIS_POS) | (DATA_W'(1) << NIS_POS);

  // reset release synchroniser
  logic [1:0] rst_ff;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_ns = rst_ff[1];

  // write decode
  logic stat_we, en_we;
  always_comb begin
    stat_we = reg_wr & (reg_addr == ADDR_STATUS);
    en_we   = reg_wr & (reg_addr == ADDR_ENABLE);
  end

  // enable word
  logic [DATA_W-1:0] en_q, en_nxt;
  always_comb en_nxt = reg_wdata & EN_MASK;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    en_q <= '0;
    else if (en_we) en_q <= en_nxt;
  end

  // sticky event bits
  logic [EVT_W-1:0] stk;
  eth_irq_sticky #(.W(EVT_W), .MASK(EV_MASK)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_ns),
    .set_i  (evt_i),
    .clr_we (stat_we),
    .clr_i  (reg_wdata[EVT_W-1:0]),
    .q_o    (stk)
  );

  // group summaries
  logic nis, ais;
  eth_irq_summary #(.W(EVT_W), .GRP(NRM_GRP)) u_sum_nrm (
    .stk_i (stk),
    .en_i  (en_q[EVT_W-1:0]),
    .sum_o (nis)
  );
  eth_irq_summary #(.W(EVT_W), .GRP(ABN_GRP)) u_sum_abn (
    .stk_i (stk),
    .en_i  (en_q[EVT_W-1:0]),
    .sum_o (ais)
  );

  // process states
  logic [ST_W-1:0] tx_q, rx_q;
  eth_irq_state_cap #(.SW(ST_W)) u_state (
    .clk   (clk),
    .rst_n (rst_ns),
    .tx_i  (tx_state_i),
    .rx_i  (rx_state_i),
    .tx_q  (tx_q),
    .rx_q  (rx_q)
  );

  // status assembly and read mux
  logic [DATA_W-1:0] status;
  always_comb begin
    status                  = '0;
    status[EVT_W-1:0]       = stk;
    status[AIS_POS]         = ais;
    status[NIS_POS]         = nis;
    status[RX_LO +: ST_W]   = rx_q;
    status[TX_LO +: ST_W]   = tx_q;
    reg_rdata = (reg_addr == ADDR_ENABLE) ? en_q : status;
    irq_o     = (nis & en_q[NIS_POS]) | (ais & en_q[AIS_POS]);
  end
endmodule

// File: rtl/eth_dma_irq_chk.sv
module eth_dma_irq_chk
  import eth_irq_pkg::*;
(
  input logic          clk,
  input logic          rst_ns,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [EVW-1:0] evt_i,
  input logic [SW-1:0] tx_state_i,
  input logic [EVW-1:0] stk,
  input logic [DW-1:0] en_q,
  input logic [SW-1:0] tx_q,
  input logic          irq_o
);
  p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    ((evt_i & EV_MASK) != '0) |=> ((stk & $past(evt_i & EV_MASK)) == $past(evt_i & EV_MASK)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_wr && reg_addr == ADDR_STATUS && evt_i == '0)
      |=> (stk == ($past(stk) & ~$past(reg_wdata[EVW-1:0]))));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_wr && reg_addr == ADDR_STATUS && ((evt_i & reg_wdata[EVW-1:0] & EV_MASK) != '0))
      |=> ((stk & $past(evt_i & reg_wdata[EVW-1:0] & EV_MASK))
           == $past(evt_i & reg_wdata[EVW-1:0] & EV_MASK)));

  p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_addr == ADDR_STATUS) |-> (reg_rdata[DW-1:23] == '0 && reg_rdata[12:11] == 2'b00));

  p_state_track_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    rst_ns |=> (tx_q == $past(tx_state_i)));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_o |-> (en_q[AIS_POS] | en_q[NIS_POS]));
endmodule

bind eth_dma_irq_ctrl eth_dma_irq_chk u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .evt_i      (evt_i),
  .tx_state_i (tx_state_i),
  .stk        (stk),
  .en_q       (en_q),
  .tx_q       (tx_q),
  .irq_o      (irq_o)
);

// File: tb/eth_dma_irq_ctrl_tb.sv
module eth_dma_irq_ctrl_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [14:0] evt_i;
  logic [2:0]  tx_state_i, rx_state_i;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [14:0] m_stk;
  logic [31:0] m_en;
  logic [2:0]  m_tx, m_rx;

  always #(CLK_NS/2) clk = ~clk;

  eth_dma_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .tx_state_i(tx_state_i), .rx_state_i(rx_state_i), .irq_o(irq_o)
  );

  function automatic logic m_nis();
    return |(m_stk & m_en[14:0] & 15'h4045);
  endfunction
  function automatic logic m_ais();
    return |(m_stk & m_en[14:0] & 15'h27BA);
  endfunction
  function automatic logic [31:0] m_status();
    return {9'b0, m_tx, m_rx, m_nis(), m_ais(), m_stk};
  endfunction

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    reg_addr = 1'b0; #1;
    cmp({tag, " status"}, reg_rdata, m_status());
    reg_addr = 1'b1; #1;
    cmp({tag, " enable R11"}, reg_rdata, m_en);
    cmp({tag, " irq R10"}, {31'b0, irq_o},
        {31'b0, (m_nis() & m_en[16]) | (m_ais() & m_en[15])});
  endtask

  // one cycle: drive at falling edge, commit at rising, return at falling
  task automatic step(input logic wr, input logic a, input logic [31:0] d, input logic [14:0] ev);
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt_i = ev;
    @(posedge clk);
    if (wr && a == 1'b0) m_stk = m_stk & ~d[14:0];
    if (wr && a == 1'b1) m_en  = d & 32'h0001E7FF;
    m_stk = m_stk | (ev & 15'h67FF);
    m_tx = tx_state_i; m_rx = rx_state_i;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; evt_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0; evt_i = '0;
    tx_state_i = '0; rx_state_i = '0;
    m_stk = '0; m_en = '0; m_tx = '0; m_rx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");

    // event sweep against four enable patterns
    for (int i = 0; i < 15; i++) begin
      for (int mode = 0; mode < 4; mode++) begin
        logic [31:0] en_w;
        en_w = ((mode & 1) ? (32'h1 << i) : 32'h0) | ((mode & 2) ? 32'h18000 : 32'h0);
        step(1'b1, 1'b1, en_w, '0);
        step(1'b0, 1'b0, '0, 15'(1 << i));
        check_all((i == 11 || i == 12) ? "R5 ignored event" : "R2 R8 R9 set");
        step(1'b1, 1'b0, ~(32'h1 << i) & 32'h7FFF, '0);
        check_all("R3 zero keeps");
        step(1'b1, 1'b0, 32'h1 << i, '0);
        check_all("R3 one clears");
      end
    end

    // all events at once, with all enables
    step(1'b1, 1'b1, 32'hFFFFFFFF, '0);
    step(1'b0, 1'b0, '0, 15'h7FFF);
    check_all("R5 R8 R9 all events");
    step(1'b1, 1'b0, 32'h0000_4045, '0);
    check_all("R3 R9 abnormal only");
    step(1'b1, 1'b0, 32'h0000_27BA, '0);
    check_all("R3 cleared all");

    // set beats clear on the same edge
    step(1'b1, 1'b0, 32'h0000_0008, 15'h0008);
    check_all("R4 set wins");
    step(1'b1, 1'b0, 32'h0000_0040, 15'h0048);
    check_all("R4 set wins two bits");
    step(1'b1, 1'b0, 32'h0000_7FFF, '0);

    // read-only upper field
    tx_state_i = 3'b110; rx_state_i = 3'b101;
    step(1'b0, 1'b0, '0, '0);
    check_all("R7 before ro write");
    step(1'b1, 1'b0, 32'hFFFE_0000, '0);
    check_all("R6 ro write ignored");
    step(1'b1, 1'b0, 32'hFF80_0000, 15'h0001);
    check_all("R6 R5 ro write with event");
    step(1'b1, 1'b0, 32'h0000_0001, '0);

    // state code sweep
    for (int t = 0; t < 8; t++) begin
      for (int r = 0; r < 8; r++) begin
        tx_state_i = 3'(t); rx_state_i = 3'(r);
        step(1'b0, 1'b0, '0, '0);
        reg_addr = 1'b0; #1;
        cmp("R7 state fields", reg_rdata, m_status());
      end
    end
    tx_state_i = 3'b000; rx_state_i = 3'b000;
    step(1'b0, 1'b0, '0, '0);

    // summary enable without event enable, and reverse
    step(1'b1, 1'b1, 32'h0001_8000, '0);
    step(1'b0, 1'b0, '0, 15'h6001);
    check_all("R8 R9 R10 no event enables");
    step(1'b1, 1'b1, 32'h0000_6001, '0);
    check_all("R10 no summary enables");
    step(1'b1, 1'b1, 32'h0000_6001 | 32'h0001_0000, '0);
    check_all("R10 normal enable only");

    // reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    m_stk = '0; m_en = '0; m_tx = '0; m_rx = '0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 second reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule